// File: doc/BRIEF.md
# Sensor Lane Pixel Steering Demultiplexer

This block sits behind one deserialised sensor readout lane. For each incoming sample it raises one of four core enables, so that the sample reaches the correct horizontal filter core. Every lane is wired to the same four cores at all times, and the enables alone decide which core takes a sample. Each sample is also tagged with flags that mark the first and the last colour group of its image row. The sample itself is widened from the sensor width to the carry width of the cores.

In full-resolution readout a lane carries one row with two interleaved colours. Only cores 0 and 1 are used. In 2x-skip readout every second 2x2 colour group is dropped in both directions. A lane then interleaves two half-width rows, and all four cores are used. One sample-index counter drives both the steering and the row-edge flags. When skip mode is active, the flags are decoded from the counter one bit higher than in full mode.

The readout mode is taken only at frame start. During row overhead, when no sample arrives, the counter holds its value.

Top module: `lane_demux`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `core_en` is 0, `row_first` and `row_last` are 0, and `out_pix` is 0.
- R2: In full mode, a sample with lane index k (k counts from 0 within a row of ROW_PIX samples) raises `core_en` bit 0 when k is even and bit 1 when k is odd. Bits 2 and 3 stay 0.
- R3: In skip mode, a sample with index k raises `core_en` bit (k mod 4). The order of bits 0 to 3 is: colour A of row 0, colour B of row 0, colour A of row 1, colour B of row 1.
- R4: In full mode, `row_first` is high for k < 2 and `row_last` is high for k >= ROW_PIX-2.
- R5: In skip mode, `row_first` is high for k < 4 and `row_last` is high for k >= ROW_PIX-4. This matches half-width rows.
- R6: A cycle with `pix_valid` low gives `core_en` = 0 and both flags 0 in the next cycle. `out_pix` holds its previous value, and the index does not advance.
- R7: All outputs appear one cycle after the sample. `out_pix` is `pix_data` zero-extended to OUT_W bits.
- R8: `sub_mode` is sampled only in a cycle with `frame_start` high (0 = full, 1 = skip). A change at any other time has no effect until the next frame start.
- R9: A `frame_start` cycle sets the index to 0. A valid sample in that same cycle is treated as index 0 of the new frame, under the newly sampled mode.
- R10: After index ROW_PIX-1 the index wraps to 0 for the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame start pulse: samples the mode and clears the index |
| sub_mode | input | 1 | Readout mode request: 0 = full, 1 = 2x skip |
| pix_valid | input | 1 | A sample is present on `pix_data` |
| pix_data | input | IN_W | Sensor sample |
| out_pix | output | OUT_W | Registered, zero-extended sample |
| core_en | output | 4 | One-hot filter core enable |
| row_first | output | 1 | Sample belongs to the first colour group of its row |
| row_last | output | 1 | Sample belongs to the last colour group of its row |

## Verification
The bench first runs two whole rows in full mode and then two whole rows in skip mode. This shows that the 2-way and 4-way steering patterns differ, that the row-edge window is 2 samples wide in full mode and 4 wide in skip mode, and that the index wraps correctly across the row boundary. The sample values are distinct and include the all-ones maximum, so any slip in latency or in zero-extension shows up. A stream broken by overhead gaps shows that the index holds across a gap rather than advancing. A mode change in the middle of a frame is followed by a frame start in the middle of a row. This separates "mode sampled only at frame start" from "mode followed live", and it shows that the index restarts at 0.

// File: rtl/lane_demux_pkg.sv
package lane_demux_pkg;
  typedef enum logic {
    RD_FULL  = 1'b0,
    RD_SKIP2 = 1'b1
  } rd_mode_e;

  localparam int unsigned N_CORES = 4;
endpackage

// File: rtl/lane_pix_counter.sv
// Per-lane sample index and frame-locked readout mode.
module lane_pix_counter
  import lane_demux_pkg::*;
#(
  parameter int unsigned ROW_PIX = 16,
  localparam int unsigned CNT_W  = $clog2(ROW_PIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             sub_mode,
  input  logic             pix_valid,
  output logic [CNT_W-1:0] idx,
  output rd_mode_e         mode
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROW_PIX - 1);

  logic [CNT_W-1:0] cnt_q;
  rd_mode_e         mode_q;

  // Index and mode that apply to the sample in this cycle.
  always_comb begin
    idx  = frame_start ? '0 : cnt_q;
    mode = frame_start ? rd_mode_e'(sub_mode) : mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= RD_FULL;
    end else begin
      if (frame_start) mode_q <= rd_mode_e'(sub_mode);
      if (pix_valid)
        cnt_q <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      else if (frame_start)
        cnt_q <= '0;
    end
  end
endmodule

// File: rtl/lane_en_decode.sv
// Decodes core enables and row-edge flags from the sample index.
module lane_en_decode
  import lane_demux_pkg::*;
#(
  parameter int unsigned ROW_PIX = 16,
  localparam int unsigned CNT_W  = $clog2(ROW_PIX)
) (
  input  logic               pix_valid,
  input  logic [CNT_W-1:0]   idx,
  input  rd_mode_e           mode,
  output logic [N_CORES-1:0] en,
  output logic               first,
  output logic               last
);
  localparam logic [CNT_W-1:0] FULL_LAST_GRP = CNT_W'(ROW_PIX / 2 - 1);
  localparam logic [CNT_W-1:0] SKIP_LAST_GRP = CNT_W'(ROW_PIX / 4 - 1);

  logic [CNT_W-1:0] grp;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    localparam logic [1:0] SEL = 2'(i);
    logic full_hit, skip_hit;
    always_comb begin
      full_hit = (SEL[1] == 1'b0) && (idx[0] == SEL[0]);
      skip_hit = (idx[1:0] == SEL);
      en[i]    = pix_valid && ((mode == RD_SKIP2) ? skip_hit : full_hit);
    end
  end

  // Skip mode looks at the index one bit higher because its rows are half as wide.
  always_comb begin
    grp   = (mode == RD_SKIP2) ? (idx >> 2) : (idx >> 1);
    first = pix_valid && (grp == '0);
    last  = pix_valid && (grp == ((mode == RD_SKIP2) ? SKIP_LAST_GRP : FULL_LAST_GRP));
  end
endmodule

// File: rtl/lane_out_reg.sv
// Output register stage: widens the sample and registers enables and flags.
module lane_out_reg
  import lane_demux_pkg::*;
#(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned OUT_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_valid,
  input  logic [IN_W-1:0]    pix_data,
  input  logic [N_CORES-1:0] en_d,
  input  logic               first_d,
  input  logic               last_d,
  output logic [OUT_W-1:0]   out_pix,
  output logic [N_CORES-1:0] core_en,
  output logic               row_first,
  output logic               row_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_pix   <= '0;
      core_en   <= '0;
      row_first <= 1'b0;
      row_last  <= 1'b0;
    end else begin
      if (pix_valid) out_pix <= OUT_W'(pix_data);
      core_en   <= en_d;
      row_first <= first_d;
      row_last  <= last_d;
    end
  end
endmodule

// File: rtl/lane_demux.sv
module lane_demux
  import lane_demux_pkg::*;
#(
  parameter int unsigned IN_W    = 10,
  parameter int unsigned OUT_W   = 12,
  parameter int unsigned ROW_PIX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             sub_mode,
  input  logic             pix_valid,
  input  logic [IN_W-1:0]  pix_data,
  output logic [OUT_W-1:0] out_pix,
  output logic [3:0]       core_en,
  output logic             row_first,
  output logic             row_last
);
  localparam int unsigned CNT_W = $clog2(ROW_PIX);

  logic [CNT_W-1:0]   idx;
  rd_mode_e           mode;
  logic [N_CORES-1:0] en_d;
  logic               first_d, last_d;

  lane_pix_counter #(.ROW_PIX(ROW_PIX)) u_cnt (
    .clk(clk), .rst(rst), .frame_start(frame_start), .sub_mode(sub_mode),
    .pix_valid(pix_valid), .idx(idx), .mode(mode)
  );

  lane_en_decode #(.ROW_PIX(ROW_PIX)) u_dec (
    .pix_valid(pix_valid), .idx(idx), .mode(mode),
    .en(en_d), .first(first_d), .last(last_d)
  );

  lane_out_reg #(.IN_W(IN_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .en_d(en_d), .first_d(first_d), .last_d(last_d),
    .out_pix(out_pix), .core_en(core_en), .row_first(row_first), .row_last(row_last)
  );
endmodule

// File: rtl/lane_demux_chk.sv
module lane_demux_chk #(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic [IN_W-1:0]  pix_data,
  input logic [OUT_W-1:0] out_pix,
  input logic [3:0]       core_en,
  input logic             row_first,
  input logic             row_last
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (core_en == 4'b0 && !row_first && !row_last && out_pix == '0));

  a_r6_gap_idle: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> (core_en == 4'b0 && !row_first && !row_last && $stable(out_pix)));

  a_r7_pix_pass: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> (out_pix == OUT_W'($past(pix_data))));

  a_r3_one_core: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> $onehot(core_en));

  a_r5_edges_apart: assert property (@(posedge clk) disable iff (rst)
    !(row_first && row_last));
endmodule

bind lane_demux lane_demux_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
  .out_pix(out_pix), .core_en(core_en), .row_first(row_first), .row_last(row_last)
);

// File: tb/tb_lane_demux.sv
module tb_lane_demux;
  localparam int IN_W = 10, OUT_W = 12, ROW_PIX = 16;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, sub_mode = 1'b0, pix_valid = 1'b0;
  logic [IN_W-1:0]  pix_data = '0;
  logic [OUT_W-1:0] out_pix;
  logic [3:0]       core_en;
  logic             row_first, row_last;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [IN_W-1:0] last_data = '0;

  always #2.5 clk = ~clk;

  lane_demux #(.IN_W(IN_W), .OUT_W(OUT_W), .ROW_PIX(ROW_PIX)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .sub_mode(sub_mode),
    .pix_valid(pix_valid), .pix_data(pix_data), .out_pix(out_pix),
    .core_en(core_en), .row_first(row_first), .row_last(row_last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One sample; its outputs are checked one edge later.
  task automatic send(input logic fs, input logic [IN_W-1:0] d, input int k,
                      input logic m, input string req);
    logic [3:0] e_en;
    @(negedge clk);
    frame_start = fs; pix_valid = 1'b1; pix_data = d;
    @(posedge clk); #1;
    frame_start = 1'b0; pix_valid = 1'b0;
    e_en = m ? 4'(1 << (k % 4)) : 4'(1 << (k % 2));
    chk({req, " en"}, 32'(core_en), 32'(e_en));
    chk({req, " first"}, 32'(row_first), 32'(m ? (k < 4) : (k < 2)));
    chk({req, " last"}, 32'(row_last), 32'(m ? (k >= ROW_PIX-4) : (k >= ROW_PIX-2)));
    chk({req, " pix R7"}, 32'(out_pix), 32'(d));
    last_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b0; frame_start = 1'b0;
      @(posedge clk); #1;
      chk("R6 gap en", 32'(core_en), 0);
      chk("R6 gap flags", 32'({row_first, row_last}), 0);
      chk("R6 gap pix held", 32'(out_pix), 32'(last_data));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 en", 32'(core_en), 0);
    chk("R1 flags", 32'({row_first, row_last}), 0);
    chk("R1 pix", 32'(out_pix), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_full_rows();
    sub_mode = 1'b0;
    for (int j = 0; j < 2 * ROW_PIX; j++)
      send(j == 0, (j == 5) ? 10'h3FF : 10'((j * 37 + 3) % 1024), j % ROW_PIX, 1'b0,
           "R2 R4 R10 full");
  endtask

  task automatic t_skip_rows();
    sub_mode = 1'b1;
    for (int j = 0; j < 2 * ROW_PIX; j++)
      send(j == 0, 10'((j * 53 + 11) % 1024), j % ROW_PIX, 1'b1, "R3 R5 R10 skip");
  endtask

  task automatic t_gaps();
    sub_mode = 1'b1;
    send(1'b1, 10'h101, 0, 1'b1, "R6 pre");
    send(1'b0, 10'h102, 1, 1'b1, "R6 pre");
    idle(3);
    send(1'b0, 10'h103, 2, 1'b1, "R6 resume");
    idle(1);
    send(1'b0, 10'h104, 3, 1'b1, "R6 resume");
    send(1'b0, 10'h105, 4, 1'b1, "R6 resume");
  endtask

  task automatic t_mode_mid();
    sub_mode = 1'b0;
    send(1'b1, 10'h011, 0, 1'b0, "R8 full");
    send(1'b0, 10'h012, 1, 1'b0, "R8 full");
    send(1'b0, 10'h013, 2, 1'b0, "R8 full");
    sub_mode = 1'b1;
    for (int j = 3; j < 8; j++) send(1'b0, 10'(j + 32), j, 1'b0, "R8 ignored change");
    // Frame start in the middle of a row: index restarts and skip mode applies.
    for (int j = 0; j < 6; j++) send(j == 0, 10'(j + 64), j, 1'b1, "R9 restart");
    sub_mode = 1'b0;
    for (int j = 6; j < 9; j++) send(1'b0, 10'(j + 64), j, 1'b1, "R8 still skip");
  endtask

  initial begin
    t_reset();
    t_full_rows();
    t_skip_rows();
    t_gaps();
    t_mode_mid();
    idle(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule